// File: doc/BRIEF.md
# Single-Wire Debug Acknowledge and Abort Handshake

This block is the target end of a one-wire, open-drain debug link. It takes host commands that have already been assembled into words, passes each one to the core, and when the core reports completion it answers the host by pulling the shared wire low for a fixed time. That falling edge starts on the target side, unlike ordinary bit slots, which the host begins. A command dropped because the core was asleep, and a command whose completion never arrives, leave the acknowledge pending with no timeout. The host clears either case by holding the wire low for a long time.

The block watches the wire through a two-flop synchronizer and counts the host's low time in serial clocks. A low of at least the sync threshold, followed by a release, is a sync request. The request cancels any waiting or unissued command and any pending acknowledge, and the block answers with a timed low reference and a one-clock speedup high. It then accepts a new command. An access that was already handed to the core still runs to completion, but it is not acknowledged. A new command is held back from the core until that access reports done. Lows that the block drives itself are masked from the low counter, so they never count as host activity.

Commands arrive on a valid/ready stream. `cmd_ready` is high only when no command or sync is outstanding, and an offered command simply waits. Issue to the core is also valid/ready: `iss_valid` and `iss_code` hold steady until `iss_ready` is seen, unless a sync drops the command. One clock cycle is one serial clock.

Top module: `dbgw_handshake`

## Requirements
- R1: Under reset and right after it, `line_drv_low`, `line_drv_high` and `iss_valid` are 0 and `cmd_ready` is 1.
- R2: `cmd_ready` goes low in the cycle after a command is accepted and stays low until that command's acknowledge ends or a sync aborts it, so acknowledges never nest. A command accepted with `core_sleep` at 0 shows on `iss_valid`/`iss_code` with the same code, held stable until `iss_ready`.
- R3: After `core_done` for the issued command, once the wire is sensed idle high, the block drives low for exactly ACK_LEN (16) cycles and then drives high for exactly one cycle. `cmd_ready` is 1 in the cycle after that high.
- R4: Without `core_done` the acknowledge never times out. The wire stays undriven and `cmd_ready` stays 0 for as long as the core is silent.
- R5: A command accepted while `core_sleep` is 1 is discarded. It is never issued and never acknowledged, and `cmd_ready` stays 0 until a sync.
- R6: A host low seen for at least SYNC_MIN (128) consecutive cycles and then released is a sync request. A low of 127 cycles is ignored and draws no response.
- R7: The sync response begins within 20 cycles of the host's release. It drives low for exactly SYNC_LEN (128) cycles, then high for one cycle, and `cmd_ready` is 1 afterwards.
- R8: A sync drops an unissued command, so `iss_valid` falls, and removes any pending acknowledge. No acknowledge pulse for the old command ever appears.
- R9: If a sync arrives while an issued access is outstanding, that access's later `core_done` produces no acknowledge. A command accepted after the sync is not issued until that `core_done`, and is issued in the cycle after it.
- R10: `line_drv_high` is never 1 together with `line_drv_low`. It lasts one cycle and only follows a cycle in which the block drove low.
- R11: However long the host low lasts, for example 400 cycles, it yields exactly one sync response.
- R12: Lows the block drives itself, whether acknowledge or sync response, are never taken as a host sync request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_in | input | 1 | Raw sampled level of the debug wire |
| line_drv_low | output | 1 | Enable for the open-drain pull-down |
| line_drv_high | output | 1 | Enable for the one-cycle speedup high driver |
| cmd_valid | input | 1 | Decoded command offered |
| cmd_ready | output | 1 | Command accepted when high with cmd_valid |
| cmd_code | input | CODE_W | Command word |
| iss_valid | output | 1 | Command offered to the core |
| iss_ready | input | 1 | Core takes the command |
| iss_code | output | CODE_W | Command word toward the core |
| core_done | input | 1 | One-cycle pulse: the core finished the issued access |
| core_sleep | input | 1 | Core is in wait or stop |

## Verification
A wrong internal state shows up on the wire lines or on the handshakes almost at once. A command tracker stuck busy shows as `cmd_ready` held low after the speedup cycle. A lost orphan flag releases `iss_valid` during the 20 cycles before the outstanding done, and a bad low counter either answers a 127-cycle low or stays silent for longer than the 20-cycle response window. Pulse length faults show as an acknowledge or reference low that is one or more cycles off its count, or a speedup that is missing or doubled, in the cycles right after the pulse.

// File: rtl/dbgw_pkg.sv
package dbgw_pkg;
  typedef enum logic [2:0] {
    CS_IDLE, CS_ISSUE, CS_BUSY, CS_ACKQ, CS_ACKING, CS_HUNG, CS_SYNCGAP, CS_SYNCDRV
  } ctl_state_t;

  typedef enum logic [1:0] {
    PS_OFF, PS_LOW, PS_HIGH
  } pulse_state_t;
endpackage

// File: rtl/dbgw_line_mon.sv
module dbgw_line_mon #(
  parameter int SYNC_MIN = 128,
  parameter int STAGES   = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_in,
  input  logic own_low,
  output logic line_idle,
  output logic sync_req
);
  localparam int CW = $clog2(SYNC_MIN + 1);
  localparam logic [CW-1:0] SAT = CW'(SYNC_MIN);

  logic [STAGES-1:0] lvl_q;
  logic [STAGES-1:0] own_q;
  logic              lvl_prev;
  logic [CW-1:0]     run_cnt;
  logic              lvl, own_seen, host_low;

  assign lvl      = lvl_q[STAGES-1];
  assign own_seen = own_q[STAGES-1];
  assign host_low = !lvl && !own_seen;

  // own drive is delayed by the synchronizer depth so it lines up with the sampled level
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q    <= '1;
      own_q    <= '0;
      lvl_prev <= 1'b1;
      run_cnt  <= '0;
    end else begin
      lvl_q    <= {lvl_q[STAGES-2:0], line_in};
      own_q    <= {own_q[STAGES-2:0], own_low};
      lvl_prev <= lvl;
      if (host_low) begin
        if (run_cnt != SAT) run_cnt <= run_cnt + 1'b1;
      end else begin
        run_cnt <= '0;
      end
    end
  end

  assign line_idle = lvl && !own_seen;
  assign sync_req  = lvl && !lvl_prev && (run_cnt == SAT);

  a_r11_single_req: assert property (@(posedge clk) disable iff (!rst_n)
    sync_req |=> !sync_req);
  a_r12_own_low_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    own_seen |=> (run_cnt == '0));
endmodule

// File: rtl/dbgw_pulse_gen.sv
module dbgw_pulse_gen
  import dbgw_pkg::*;
#(
  parameter int ACK_LEN  = 16,
  parameter int SYNC_LEN = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic long_sel,
  input  logic abort,
  output logic drv_low,
  output logic drv_high,
  output logic done
);
  localparam int MAXL = (ACK_LEN > SYNC_LEN) ? ACK_LEN : SYNC_LEN;
  localparam int LW   = $clog2(MAXL + 1);

  pulse_state_t  state;
  logic [LW-1:0] cnt;
  logic [LW-1:0] run_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= PS_OFF;
      cnt   <= '0;
    end else if (abort) begin
      state <= PS_OFF;
    end else begin
      case (state)
        PS_OFF: if (start) begin
          state <= PS_LOW;
          cnt   <= long_sel ? LW'(SYNC_LEN - 1) : LW'(ACK_LEN - 1);
        end
        PS_LOW: if (cnt == '0) state <= PS_HIGH;
                else cnt <= cnt - 1'b1;
        PS_HIGH: state <= PS_OFF;
        default: state <= PS_OFF;
      endcase
    end
  end

  assign drv_low  = (state == PS_LOW);
  assign drv_high = (state == PS_HIGH);
  assign done     = (state == PS_HIGH);

  // checker counter: length of the current low run
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         run_len <= '0;
    else if (drv_low)   run_len <= run_len + 1'b1;
    else if (!drv_high) run_len <= '0;
  end

  a_r10_not_both: assert property (@(posedge clk) disable iff (!rst_n)
    !(drv_low && drv_high));
  a_r10_high_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    drv_high |=> !drv_high);
  a_r10_high_after_low: assert property (@(posedge clk) disable iff (!rst_n)
    drv_high |-> $past(drv_low));
  a_r3_pulse_len: assert property (@(posedge clk) disable iff (!rst_n)
    drv_high |-> (run_len == LW'(ACK_LEN) || run_len == LW'(SYNC_LEN)));
endmodule

// File: rtl/dbgw_cmd_ctl.sv
module dbgw_cmd_ctl
  import dbgw_pkg::*;
#(
  parameter int CODE_W   = 8,
  parameter int RESP_GAP = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [CODE_W-1:0] cmd_code,
  output logic              iss_valid,
  input  logic              iss_ready,
  output logic [CODE_W-1:0] iss_code,
  input  logic              core_done,
  input  logic              core_sleep,
  input  logic              sync_req,
  input  logic              line_idle,
  input  logic              pulse_done,
  output logic              pulse_start,
  output logic              pulse_long
);
  localparam int GW = $clog2(RESP_GAP + 1);

  ctl_state_t        state;
  logic [CODE_W-1:0] code_q;
  logic [GW-1:0]     gap_cnt;
  logic              orphan;

  assign cmd_ready   = (state == CS_IDLE) && !sync_req;
  assign iss_valid   = (state == CS_ISSUE) && !orphan;
  assign iss_code    = code_q;
  assign pulse_start = !sync_req &&
                       (((state == CS_ACKQ) && line_idle) ||
                        ((state == CS_SYNCGAP) && (gap_cnt == '0)));
  assign pulse_long  = (state == CS_SYNCGAP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= CS_IDLE;
      code_q  <= '0;
      gap_cnt <= '0;
    end else if (sync_req) begin
      state   <= CS_SYNCGAP;
      gap_cnt <= GW'(RESP_GAP - 1);
    end else begin
      case (state)
        CS_IDLE: if (cmd_valid) begin
          code_q <= cmd_code;
          state  <= core_sleep ? CS_HUNG : CS_ISSUE;
        end
        CS_ISSUE:   if (iss_valid && iss_ready) state <= CS_BUSY;
        CS_BUSY:    if (core_done) state <= CS_ACKQ;
        CS_ACKQ:    if (pulse_start) state <= CS_ACKING;
        CS_ACKING:  if (pulse_done) state <= CS_IDLE;
        CS_HUNG:    state <= CS_HUNG;
        CS_SYNCGAP: if (gap_cnt == '0) state <= CS_SYNCDRV;
                    else gap_cnt <= gap_cnt - 1'b1;
        CS_SYNCDRV: if (pulse_done) state <= CS_IDLE;
        default:    state <= CS_IDLE;
      endcase
    end
  end

  // an access cut loose by a sync still finishes; its completion is swallowed here
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                           orphan <= 1'b0;
    else if ((state == CS_BUSY) && sync_req && !core_done) orphan <= 1'b1;
    else if (core_done)                                    orphan <= 1'b0;
  end

  a_r2_no_nest: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> !cmd_ready);
  a_r2_iss_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && !iss_ready && !sync_req) |=> (iss_valid && $stable(iss_code)));
  a_r8_sync_clears: assert property (@(posedge clk) disable iff (!rst_n)
    sync_req |=> (!iss_valid && !cmd_ready));
  a_r5_hung_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (state == CS_HUNG) |=> (!iss_valid && !pulse_start && !pulse_done) || $past(sync_req) || sync_req);
endmodule

// File: rtl/dbgw_handshake.sv
module dbgw_handshake #(
  parameter int CODE_W   = 8,
  parameter int ACK_LEN  = 16,
  parameter int SYNC_MIN = 128,
  parameter int SYNC_LEN = 128,
  parameter int RESP_GAP = 4,
  parameter int STAGES   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_in,
  output logic              line_drv_low,
  output logic              line_drv_high,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [CODE_W-1:0] cmd_code,
  output logic              iss_valid,
  input  logic              iss_ready,
  output logic [CODE_W-1:0] iss_code,
  input  logic              core_done,
  input  logic              core_sleep
);
  logic line_idle, sync_req, pulse_start, pulse_long, pulse_done;

  dbgw_line_mon #(.SYNC_MIN(SYNC_MIN), .STAGES(STAGES)) mon_i (
    .clk(clk), .rst_n(rst_n), .line_in(line_in), .own_low(line_drv_low),
    .line_idle(line_idle), .sync_req(sync_req)
  );

  dbgw_cmd_ctl #(.CODE_W(CODE_W), .RESP_GAP(RESP_GAP)) ctl_i (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_code(cmd_code),
    .iss_valid(iss_valid), .iss_ready(iss_ready), .iss_code(iss_code),
    .core_done(core_done), .core_sleep(core_sleep),
    .sync_req(sync_req), .line_idle(line_idle), .pulse_done(pulse_done),
    .pulse_start(pulse_start), .pulse_long(pulse_long)
  );

  dbgw_pulse_gen #(.ACK_LEN(ACK_LEN), .SYNC_LEN(SYNC_LEN)) gen_i (
    .clk(clk), .rst_n(rst_n), .start(pulse_start), .long_sel(pulse_long),
    .abort(sync_req), .drv_low(line_drv_low), .drv_high(line_drv_high),
    .done(pulse_done)
  );

  a_r7_sync_then_busy: assert property (@(posedge clk) disable iff (!rst_n)
    sync_req |=> (!line_drv_low && !cmd_ready));
endmodule

// File: tb/dbgw_handshake_tb_top.sv
`timescale 1ns/1ps
module dbgw_handshake_tb_top;
  localparam int CODE_W   = 8;
  localparam int ACK_LEN  = 16;
  localparam int SYNC_MIN = 128;
  localparam int SYNC_LEN = 128;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0;
  logic host_low = 1'b0;
  logic line_in, line_drv_low, line_drv_high;
  logic cmd_valid = 1'b0, cmd_ready;
  logic [CODE_W-1:0] cmd_code = '0;
  logic iss_valid, iss_ready = 1'b0;
  logic [CODE_W-1:0] iss_code;
  logic core_done = 1'b0, core_sleep = 1'b0;

  assign line_in = !(host_low || line_drv_low);

  dbgw_handshake dut_i (
    .clk(clk), .rst_n(rst_n), .line_in(line_in),
    .line_drv_low(line_drv_low), .line_drv_high(line_drv_high),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_code(cmd_code),
    .iss_valid(iss_valid), .iss_ready(iss_ready), .iss_code(iss_code),
    .core_done(core_done), .core_sleep(core_sleep)
  );

  int n_vec = 0, n_bad = 0;
  bit finished = 0;

  function automatic bit exp_sync(input int len);
    return len >= SYNC_MIN;
  endfunction

  task automatic chk(input string req, input longint act, input longint exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  // R10: drive high and drive low never together
  always @(negedge clk) begin
    if (rst_n && line_drv_low && line_drv_high) begin
      n_vec++; n_bad++;
      $display("FAIL R10 actual=%0d expected=%0d", 1, 0);
    end
  end

  task automatic send_cmd(input logic [CODE_W-1:0] code);
    cmd_code  = code;
    cmd_valid = 1'b1;
    for (int i = 0; i < 1000 && !cmd_ready; i++) tick();
    tick();
    cmd_valid = 1'b0;
    chk("R2 ready low after accept", cmd_ready, 0);
  endtask

  task automatic wait_issue(input logic [CODE_W-1:0] code, input bit stall);
    bit got = 0;
    for (int i = 0; i < 200 && !got; i++) begin
      logic r;
      r = 1'b0;
      if (iss_valid) begin
        chk("R2 issue code", iss_code, code);
        r = stall ? 1'($urandom % 2) : 1'b1;
      end
      iss_ready = r;
      tick();
      if (r) got = 1;
    end
    iss_ready = 1'b0;
    chk("R2 issued", got, 1);
  endtask

  task automatic measure_pulse(input int exp_len, input string req, input int max_wait);
    int w = 0, len = 0;
    while (!line_drv_low && w < max_wait) begin tick(); w++; end
    chk({req, " pulse start"}, line_drv_low, 1);
    while (line_drv_low && len < 1000) begin len++; tick(); end
    chk({req, " low length"}, len, exp_len);
    chk("R10 speedup present", line_drv_high, 1);
    tick();
    chk("R10 speedup one cycle", line_drv_high, 0);
  endtask

  task automatic quiet(input int n, input string req);
    int seen = 0;
    for (int i = 0; i < n; i++) begin
      if (line_drv_low || line_drv_high) seen++;
      tick();
    end
    chk({req, " wire undriven"}, seen, 0);
  endtask

  task automatic host_pulse(input int len);
    host_low = 1'b1;
    repeat (len) tick();
    host_low = 1'b0;
  endtask

  task automatic do_sync(input int len);
    bit rdy_before;
    rdy_before = cmd_ready;
    host_pulse(len);
    if (exp_sync(len)) begin
      measure_pulse(SYNC_LEN, "R7", 20);
      chk("R7 ready after sync", cmd_ready, 1);
    end else begin
      quiet(60, "R6");
      chk("R6 ready unchanged", cmd_ready, rdy_before);
    end
  endtask

  task automatic full_tx(input logic [CODE_W-1:0] code, input int lat);
    send_cmd(code);
    wait_issue(code, 1'b1);
    quiet(lat, "R4");
    chk("R4 still pending", cmd_ready, 0);
    core_done = 1'b1; tick(); core_done = 1'b0;
    measure_pulse(ACK_LEN, "R3", 10);
    chk("R3 ready after ack", cmd_ready, 1);
    quiet(5, "R12");
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) tick();
    chk("R1 drv_low", line_drv_low, 0);
    chk("R1 drv_high", line_drv_high, 0);
    chk("R1 iss_valid", iss_valid, 0);
    chk("R1 cmd_ready", cmd_ready, 1);
    rst_n = 1'b1;
    tick();
    chk("R1 ready after reset", cmd_ready, 1);
    chk("R1 wire after reset", line_drv_low, 0);

    // random transactions interleaved with near-threshold host lows
    for (int i = 0; i < 24; i++) begin
      full_tx(CODE_W'($urandom), int'($urandom_range(0, 15)));
      if (i % 4 == 0) do_sync(int'($urandom_range(120, 136)));
    end

    // R6: exact threshold edges
    do_sync(SYNC_MIN - 1);
    do_sync(SYNC_MIN);

    // R8: sync drops an unissued command
    send_cmd(8'h5A);
    tick();
    chk("R8 issue offered", iss_valid, 1);
    do_sync(SYNC_MIN);
    chk("R8 issue dropped", iss_valid, 0);
    quiet(30, "R8");

    // R4 then R9: issued access never completes, sync, orphan completion
    send_cmd(8'h11);
    wait_issue(8'h11, 1'b0);
    quiet(300, "R4");
    chk("R4 ready low", cmd_ready, 0);
    do_sync(SYNC_MIN + 10);
    send_cmd(8'h22);
    begin
      int early = 0;
      for (int i = 0; i < 20; i++) begin
        if (iss_valid) early++;
        tick();
      end
      chk("R9 issue held", early, 0);
    end
    core_done = 1'b1; tick(); core_done = 1'b0;
    chk("R9 issue released", iss_valid, 1);
    chk("R9 code", iss_code, 8'h22);
    quiet(8, "R9 no orphan ack");
    wait_issue(8'h22, 1'b0);
    core_done = 1'b1; tick(); core_done = 1'b0;
    measure_pulse(ACK_LEN, "R3", 10);

    // R5: command while core sleeps
    core_sleep = 1'b1;
    send_cmd(8'h77);
    core_sleep = 1'b0;
    begin
      int issued = 0;
      for (int i = 0; i < 50; i++) begin
        if (iss_valid) issued++;
        tick();
      end
      chk("R5 never issued", issued, 0);
    end
    quiet(20, "R5");
    chk("R5 stays busy", cmd_ready, 0);
    do_sync(200);

    // R11: very long low gives one response only
    do_sync(400);
    quiet(200, "R11");
    full_tx(8'hC3, 3);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule